// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a fast system clock into a slow, evenly spaced strobe for a serial channel. A single 32-bit control word sets everything: a run bit, a coarse prescaler switch, and a 12-bit reload value. While running, the block emits a one-clock tick once per programmed interval. It also provides a square wave that flips on every tick, for a channel that wants a clock edge rather than an enable.

The interval is the reload value plus one, counted in input clocks. With the prescaler switched in, it is counted in groups of sixteen input clocks, which reaches very low baud rates without a wider counter. A new reload value written while the generator runs does not cut the current interval short; it applies from the next reload. Clearing the run bit returns the counter, the prescaler and the square wave to their idle state, so every restart begins from a known point. Several copies can sit side by side, one per rate needed. Steering their outputs to channels happens outside this block.

Top module: `baud_clk_gen`

## Requirements
- R1: The control word resets to zero and reads back on `cfg_rdata`, all 32 bits exactly as last written, one cycle after the write.
- R2: The reload value N (0 to 4095) is taken from control bits [12:1]. Bit 0 and every bit other than 1..13 and 16 have no effect on the output timing.
- R3: Control bit 16 is the run bit. From the second cycle after a write that clears it, `tick_o` stays low and `sq_o` stays low.
- R4: When control bit 13 is set, consecutive ticks are 16*(N+1) input clocks apart.
- R5: When bit 13 is clear, consecutive ticks are N+1 clocks apart and each tick lasts one clock, except that N=0 holds `tick_o` high every clock. The first tick after a write that sets the run bit is high in the cycle N+2 clocks after that write's edge.
- R6: `sq_o` is low when idle and changes value in exactly the cycles in which `tick_o` is high, so its period is twice the tick interval.
- R7: A reload value written while running leaves the interval in progress unchanged and governs every interval after it.
- R8: Clearing the run bit resets the counter and prescaler. After the run bit is set again, the first tick again follows R5's start-up latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word |
| tick_o | output | 1 | One-clock baud strobe |
| sq_o | output | 1 | Square wave that flips on each tick |

## Verification
The bench targets the extremes of the reload field. N=0 must give a continuous strobe, and N=4095 must give a 4096-clock interval. A counter that is off by one, or one that wraps inside 12 bits, shows up as a wrong measured gap. A reload value changed in the middle of an interval must leave that interval at its old length. A design that loads the new value at once would shorten it. Disabling and then re-enabling must reproduce the start-up latency exactly. A design that keeps a stale count or prescaler phase would tick early, and one that keeps the square-wave level would leave `sq_o` high while idle.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  localparam int CFG_W   = 32;
  localparam int DIV_W   = 12;
  localparam int DIV_LSB = 1;
  localparam int PRE_BIT = 13;
  localparam int EN_BIT  = 16;
  localparam int PRE_DIV = 16;

  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    logic en;
    logic pre16;
    div_t div;
  } cfg_t;

  // Pull the fields the timing logic needs out of the raw control word.
  function automatic cfg_t bgen_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.en    = w[EN_BIT];
    c.pre16 = w[PRE_BIT];
    c.div   = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  // Interval between ticks, in input clocks.
  function automatic int unsigned bgen_period(input cfg_t c);
    return (int'(c.div) + 1) * (c.pre16 ? PRE_DIV : 1);
  endfunction
endpackage

// File: rtl/bgen_cfg_reg.sv
module bgen_cfg_reg
  import bgen_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output cfg_t         cfg_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (we_i) word_q <= wdata_i;
  end

  assign rdata_o = word_q;
  assign cfg_o   = bgen_decode(word_q);

  AST_CFG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o == $past(wdata_i)); // R1
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sel_i,
  output logic step_o
);
  generate
    if (DIV > 1) begin : g_pre
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      logic          pre_wrap;

      assign pre_wrap = run_i && sel_i && (pre_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (!run_i || !sel_i) pre_q <= '0;
        else if (pre_q == LAST)    pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
      end

      assign step_o = sel_i ? pre_wrap : run_i;

      AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && pre_wrap) |=> !pre_wrap); // R4
    end else begin : g_nopre
      assign step_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/bgen_divider.sv
module bgen_divider
  import bgen_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] field_i,
  output logic         run_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         primed_q;

  assign run_o  = en_i && primed_q;
  assign wrap_o = step_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (!primed_q) begin
      cnt_q    <= field_i;
      primed_q <= 1'b1;
    end else if (step_i) begin
      cnt_q <= (cnt_q == '0) ? field_i : cnt_q - 1'b1;
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == $past(field_i)); // R7
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !primed_q); // R8
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import bgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             tick_o,
  output logic             sq_o
);
  cfg_t cfg;
  logic run;
  logic step;
  logic wrap;
  logic tick_q;
  logic sq_q;

  bgen_cfg_reg #(.W(CFG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .rdata_o(cfg_rdata), .cfg_o(cfg)
  );

  bgen_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sel_i(cfg.pre16), .step_o(step)
  );

  bgen_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(cfg.en), .step_i(step),
    .field_i(cfg.div), .run_o(run), .wrap_o(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else if (!cfg.en) begin
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (wrap) sq_q <= ~sq_q;
    end
  end

  assign tick_o = tick_q;
  assign sq_o   = sq_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q); // R3
  AST_SQ_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> sq_q != $past(sq_q)); // R6
  AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_q && cfg.en && $past(cfg.en)) |-> $stable(sq_q)); // R6
endmodule

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick_o, sq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  baud_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_o(tick_o), .sq_o(sq_o)
  );

  function automatic logic [31:0] mk(input bit en, input bit pre, input int n);
    return (32'(en) << 16) | (32'(pre) << 13) | (32'(n & 12'hFFF) << 1);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Wait for a tick, then count clocks up to the following tick.
  task automatic meas(output int gap);
    int w = 0;
    while (!tick_o && w < 70000) begin @(negedge clk); w++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick_o && gap < 70000);
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 32'h0, "R1 reset word", cfg_rdata, 0);
    chk(!tick_o, "R3 reset tick", tick_o, 0);
    chk(!sq_o, "R6 reset sq", sq_o, 0);
  endtask

  task automatic t_readback;
    wr(32'hA5A4_5A5B);
    chk(cfg_rdata == 32'hA5A4_5A5B, "R1 readback", cfg_rdata, 32'hA5A4_5A5B);
    wr(32'h0000_0001);
    chk(cfg_rdata == 32'h1, "R1 readback2", cfg_rdata, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_latency(input int n, input string req);
    int i = 0;
    wr(mk(1, 0, n));
    while (!tick_o && i < 10000) begin @(negedge clk); i++; end
    chk(i == n + 2, req, i, n + 2);
  endtask

  task automatic t_period(input logic [31:0] w, input int expv, input string req);
    int g;
    wr(w);
    meas(g); chk(g == expv, req, g, expv);
    meas(g); chk(g == expv, req, g, expv);
    wr(32'h0); @(negedge clk);
  endtask

  task automatic t_width;
    int hi = 0;
    wr(mk(1, 0, 4));
    while (!tick_o) @(negedge clk);
    for (int k = 0; k < 20; k++) begin if (tick_o) hi++; @(negedge clk); end
    chk(hi == 4, "R5 one-cycle ticks in 20 cycles", hi, 4);
    wr(32'h0); @(negedge clk);
  endtask

  task automatic t_square;
    logic prev;
    int bad = 0;
    wr(mk(1, 0, 3));
    prev = sq_o;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if ((sq_o != prev) != tick_o) bad++;
      prev = sq_o;
    end
    chk(bad == 0, "R6 sq flips only with tick", bad, 0);
    wr(32'h0); @(negedge clk);
    chk(!sq_o, "R6 sq idle low", sq_o, 0);
  endtask

  task automatic t_midchange;
    int g;
    int c;
    wr(mk(1, 0, 9));
    meas(g);
    chk(g == 10, "R7 old interval", g, 10);
    wr(mk(1, 0, 2));
    c = 1;
    while (!tick_o && c < 100) begin @(negedge clk); c++; end
    chk(c == 10, "R7 interval in progress kept", c, 10);
    meas(g);
    chk(g == 3, "R7 new interval", g, 3);
  endtask

  task automatic t_disable;
    int seen = 0;
    wr(mk(0, 0, 2));
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      if (tick_o || sq_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R3 idle quiet", seen, 0);
    // prescaler partway through its count, then disable and restart
    wr(mk(1, 1, 1));
    repeat (7) @(negedge clk);
    wr(32'h0);
    t_latency(6, "R8 restart latency");
    wr(32'h0); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_latency(5, "R5 first tick latency");
    wr(32'h0); @(negedge clk);
    t_period(mk(1, 0, 0), 1, "R5 N=0 period");
    t_period(mk(1, 0, 3), 4, "R5 N=3 period");
    t_period(mk(1, 0, 4095), 4096, "R2 N=4095 period");
    t_period(mk(1, 0, 6) | 32'hFFE2_C001, 7, "R2 unused bits ignored");
    t_period(mk(1, 1, 2), 48, "R4 prescaled N=2");
    t_period(mk(1, 1, 100), 1616, "R4 prescaled N=100");
    t_width();
    t_square();
    t_midchange();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule